// File: doc/BRIEF.md
# DDR Burst-of-Two SRAM Front-End

This block is the synchronous front end of a separate-I/O, double-data-rate static memory with one shared address bus. It runs on a single clock at twice the command rate. An internal half-cycle marker splits the clock edges into "K" edges and "K#" edges. The marker is visible on `k_half`: that output is high during every cycle whose closing edge is a K edge. Commands are sampled only on K edges, so one read or write can start on each of them. Every access moves an uninterruptible pair of words: the lower word first, then the upper word.

Write data arrives one K edge after the write command, as two beats on consecutive edges. Each beat carries its own active-low byte enables. The data sits in a late-write register and reaches the internal array only when the next write starts its data phase, or when a flush is requested. Reads merge the newest buffered bytes over the array contents, so any sequence of reads, writes and idle slots stays coherent with no gap between them. Read words are driven through a registered output. A valid flag and an output-enable flag take the place of a three-state bus.

Top module: `ddrb_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rdata_valid` and `rdata_oe` are 0 and `rdata` is all zeros.
- R2: `sel_n`, `is_read`, `addr` and `flush` are sampled only at edges that close a cycle with `k_half` high. Values driven on them while `k_half` is low have no effect.
- R3: A read accepted at K edge E (`sel_n`=0, `is_read`=1) drives the lower word (array word 2*addr+0) in the cycle after the edge that follows E. That cycle has `k_half` high. The upper word (2*addr+1) follows in the next cycle. `rdata_valid` and `rdata_oe` are high in exactly those cycles.
- R4: Reads accepted on consecutive K edges produce an unbroken stream of valid words, in command order, lower word before upper word.
- R5: For a write accepted at K edge E (`is_read`=0), the lower-word data beat is taken from `wdata`/`lane_we_n` at the next K edge. The upper-word beat is taken at the edge right after that.
- R6: `lane_we_n` is active low, and bit i covers byte i (`wdata` bits 8i+7..8i). Each beat carries its own enables. A byte whose enable is 1 keeps its previous contents.
- R7: A read that directly follows a write, even to the same address, returns the buffered write bytes. The merge is per byte, and unwritten bytes return the stored value.
- R8: A buffered write is committed when the next write captures its first beat, or when `flush` is high at a K edge with no capture pending. The data stays readable, unchanged, after it is committed.
- R9: With IDLE_ZERO=1, `rdata` is all zeros in every cycle where `rdata_oe` is low.
- R10: A K edge with `sel_n`=1 or with a write command produces no read output two cycles later. Data inputs at edges with no write beat due leave the stored contents unchanged.
- R11: Reads, writes and idle slots may follow one another in any order on consecutive K edges, and every read returns the latest written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; edges alternate between K and K# |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Command select, active low |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word-pair address |
| wdata | input | DW | Write data beat |
| lane_we_n | input | DW/BYTE_W | Per-byte write enables of the current beat, active low |
| flush | input | 1 | Request to commit the buffered write |
| k_half | output | 1 | High in cycles whose closing edge is a K edge |
| rdata | output | DW | Read data word |
| rdata_valid | output | 1 | `rdata` carries a read word |
| rdata_oe | output | 1 | Output drive enable; low means the bus is released |

## Verification
A read command sampled at a K edge shows its lower word two clock cycles later and its upper word three cycles later. The bench therefore checks each read word in the two cycles after the slot that issued it. It samples on falling edges, where the registered outputs are settled. The two write beats are driven one and one-and-a-half command slots after the write command. The reference model updates its memory image at that point, before it computes the expected value of any read in the same slot. That is the order the forwarding has to honour. Every cycle that carries no read word is checked for a released, all-zero output. Command-like noise is driven on every K# half-cycle, so a design that sampled commands on the wrong edge would produce an unexpected output.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

   // command decoded at a K edge
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // which edge closes the current cycle
   typedef enum logic {
      HALF_K  = 1'b0,
      HALF_KB = 1'b1
   } half_e;

endpackage

// File: rtl/ddrb_phase.sv
module ddrb_phase
   import ddrb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic k_edge
);

   half_e half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= HALF_K;
      else        half_q <= (half_q == HALF_K) ? HALF_KB : HALF_K;
   end

   assign k_edge = (half_q == HALF_K);

endmodule

// File: rtl/ddrb_wreg.sv
module ddrb_wreg #(
   parameter int AW = 4,
   parameter int DW = 32,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          k_edge,
   input  logic          wr_cmd,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] wdata,
   input  logic [NB-1:0] lane_we_n,
   input  logic          flush,
   output logic          commit_en,
   output logic          pend_valid,
   output logic          pend_full,
   output logic [AW-1:0] pend_addr,
   output logic [DW-1:0] pend_d0,
   output logic [DW-1:0] pend_d1,
   output logic [NB-1:0] pend_m0,
   output logic [NB-1:0] pend_m1
);

   logic          due0_q, due1_q;
   logic [AW-1:0] waddr_q;

   // commit the old burst on the edge that captures a new first beat,
   // or on a flush at a K edge
   assign commit_en = k_edge && pend_valid && (due0_q || flush);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         due0_q     <= 1'b0;
         due1_q     <= 1'b0;
         waddr_q    <= '0;
         pend_valid <= 1'b0;
         pend_full  <= 1'b0;
         pend_addr  <= '0;
         pend_d0    <= '0;
         pend_d1    <= '0;
         pend_m0    <= '0;
         pend_m1    <= '0;
      end else if (k_edge) begin
         due0_q <= wr_cmd;
         if (wr_cmd) waddr_q <= cmd_addr;
         if (due0_q) begin
            pend_addr  <= waddr_q;
            pend_d0    <= wdata;
            pend_m0    <= ~lane_we_n;
            pend_valid <= 1'b1;
            pend_full  <= 1'b0;
            due1_q     <= 1'b1;
         end else if (flush) begin
            pend_valid <= 1'b0;
            pend_full  <= 1'b0;
         end
      end else if (due1_q) begin
         pend_d1   <= wdata;
         pend_m1   <= ~lane_we_n;
         pend_full <= 1'b1;
         due1_q    <= 1'b0;
      end
   end

endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
   parameter int DEPTH  = 16,
   parameter int AW     = 4,
   parameter int DW     = 32,
   parameter int NB     = 4,
   parameter int BYTE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wd0,
   input  logic [DW-1:0] wd1,
   input  logic [NB-1:0] wm0,
   input  logic [NB-1:0] wm1,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rd0,
   output logic [DW-1:0] rd1
);

   logic [1:0][DW-1:0] wd_all;
   logic [1:0][NB-1:0] wm_all;
   logic [1:0][DW-1:0] rd_all;

   assign wd_all = {wd1, wd0};
   assign wm_all = {wm1, wm0};

   // one bank per burst position
   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            for (int l = 0; l < NB; l++)
               if (wm_all[b][l])
                  mem[waddr][l*BYTE_W +: BYTE_W] <= wd_all[b][l*BYTE_W +: BYTE_W];
         end
      end

      assign rd_all[b] = mem[raddr];
   end

   assign rd0 = rd_all[0];
   assign rd1 = rd_all[1];

endmodule

// File: rtl/ddrb_rdout.sv
module ddrb_rdout #(
   parameter int AW        = 4,
   parameter int DW        = 32,
   parameter int NB        = 4,
   parameter int BYTE_W    = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          k_edge,
   input  logic          rd_cmd,
   input  logic [AW-1:0] cmd_addr,
   output logic [AW-1:0] raddr,
   input  logic [DW-1:0] arr0,
   input  logic [DW-1:0] arr1,
   input  logic          pend_valid,
   input  logic          pend_full,
   input  logic [AW-1:0] pend_addr,
   input  logic [DW-1:0] pend_d0,
   input  logic [DW-1:0] pend_d1,
   input  logic [NB-1:0] pend_m0,
   input  logic [NB-1:0] pend_m1,
   output logic [DW-1:0] rdata,
   output logic          rdata_valid,
   output logic          rdata_oe
);

   logic          rdue0_q, rdue1_q;
   logic [AW-1:0] ra_q;
   logic          hit;
   logic [NB-1:0] en0, en1;
   logic [DW-1:0] mg0, mg1;
   logic          drive_nxt;
   logic [DW-1:0] beat_nxt;

   assign raddr = ra_q;
   assign hit   = pend_valid && (pend_addr == ra_q);
   assign en0   = hit ? pend_m0 : '0;
   assign en1   = (hit && pend_full) ? pend_m1 : '0;

   // byte-granular merge of buffered write over array contents
   for (genvar l = 0; l < NB; l++) begin : g_lane
      assign mg0[l*BYTE_W +: BYTE_W] = en0[l] ? pend_d0[l*BYTE_W +: BYTE_W]
                                              : arr0[l*BYTE_W +: BYTE_W];
      assign mg1[l*BYTE_W +: BYTE_W] = en1[l] ? pend_d1[l*BYTE_W +: BYTE_W]
                                              : arr1[l*BYTE_W +: BYTE_W];
   end

   always_comb begin
      drive_nxt = 1'b0;
      beat_nxt  = mg0;
      if (!k_edge && rdue0_q) begin
         drive_nxt = 1'b1;
         beat_nxt  = mg0;
      end else if (k_edge && rdue1_q) begin
         drive_nxt = 1'b1;
         beat_nxt  = mg1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdue0_q     <= 1'b0;
         rdue1_q     <= 1'b0;
         ra_q        <= '0;
         rdata_valid <= 1'b0;
         rdata_oe    <= 1'b0;
      end else begin
         rdata_valid <= drive_nxt;
         rdata_oe    <= drive_nxt;
         if (k_edge) begin
            rdue0_q <= rd_cmd;
            rdue1_q <= 1'b0;
            if (rd_cmd) ra_q <= cmd_addr;
         end else begin
            rdue1_q <= rdue0_q;
         end
      end
   end

   if (IDLE_ZERO) begin : g_idle_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= drive_nxt ? beat_nxt : '0;
      end
   end else begin : g_idle_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         rdata <= '0;
         else if (drive_nxt) rdata <= beat_nxt;
      end
   end

endmodule

// File: rtl/ddrb_sram.sv
module ddrb_sram
   import ddrb_pkg::*;
#(
   parameter int  DEPTH     = 16,
   parameter int  DW        = 32,
   parameter int  BYTE_W    = 8,
   parameter bit  IDLE_ZERO = 1'b1,
   localparam int AW        = $clog2(DEPTH),
   localparam int NB        = DW / BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          is_read,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [NB-1:0] lane_we_n,
   input  logic          flush,
   output logic          k_half,
   output logic [DW-1:0] rdata,
   output logic          rdata_valid,
   output logic          rdata_oe
);

   if (DW % BYTE_W != 0) begin : g_bad_width
      $error("ddrb_sram: DW must be a multiple of BYTE_W");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("ddrb_sram: DEPTH must be a power of two, at least 2");
   end

   logic          k_edge;
   op_e           op;
   logic          rd_cmd, wr_cmd;
   logic          commit_en, pend_valid, pend_full;
   logic [AW-1:0] pend_addr, raddr;
   logic [DW-1:0] pend_d0, pend_d1, arr0, arr1;
   logic [NB-1:0] pend_m0, pend_m1;

   assign op     = sel_n ? OP_IDLE : (is_read ? OP_READ : OP_WRITE);
   assign rd_cmd = k_edge && (op == OP_READ);
   assign wr_cmd = k_edge && (op == OP_WRITE);
   assign k_half = k_edge;

   ddrb_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .k_edge (k_edge)
   );

   ddrb_wreg #(.AW(AW), .DW(DW), .NB(NB)) u_wreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .k_edge     (k_edge),
      .wr_cmd     (wr_cmd),
      .cmd_addr   (addr),
      .wdata      (wdata),
      .lane_we_n  (lane_we_n),
      .flush      (flush),
      .commit_en  (commit_en),
      .pend_valid (pend_valid),
      .pend_full  (pend_full),
      .pend_addr  (pend_addr),
      .pend_d0    (pend_d0),
      .pend_d1    (pend_d1),
      .pend_m0    (pend_m0),
      .pend_m1    (pend_m1)
   );

   ddrb_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NB(NB), .BYTE_W(BYTE_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit_en),
      .waddr (pend_addr),
      .wd0   (pend_d0),
      .wd1   (pend_d1),
      .wm0   (pend_m0),
      .wm1   (pend_m1),
      .raddr (raddr),
      .rd0   (arr0),
      .rd1   (arr1)
   );

   ddrb_rdout #(.AW(AW), .DW(DW), .NB(NB), .BYTE_W(BYTE_W), .IDLE_ZERO(IDLE_ZERO)) u_rdout (
      .clk         (clk),
      .rst_n       (rst_n),
      .k_edge      (k_edge),
      .rd_cmd      (rd_cmd),
      .cmd_addr    (addr),
      .raddr       (raddr),
      .arr0        (arr0),
      .arr1        (arr1),
      .pend_valid  (pend_valid),
      .pend_full   (pend_full),
      .pend_addr   (pend_addr),
      .pend_d0     (pend_d0),
      .pend_d1     (pend_d1),
      .pend_m0     (pend_m0),
      .pend_m1     (pend_m1),
      .rdata       (rdata),
      .rdata_valid (rdata_valid),
      .rdata_oe    (rdata_oe)
   );

endmodule

// File: rtl/ddrb_sram_chk.sv
module ddrb_sram_chk #(
   parameter int DW        = 32,
   parameter bit IDLE_ZERO = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          k_half,
   input logic          sel_n,
   input logic          is_read,
   input logic          rdata_valid,
   input logic          rdata_oe,
   input logic [DW-1:0] rdata,
   input logic          pend_valid,
   input logic          pend_full
);

   // R3: a read command yields a driven word two cycles later
   p_read_to_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (k_half && !sel_n && is_read) |=> ##1 (rdata_valid && rdata_oe));

   // R3: a lower word is always followed by its upper word
   p_beat_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_valid && k_half) |=> (rdata_valid && !k_half));

   // R10: no read command, no read word
   p_no_cmd_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (k_half && (sel_n || !is_read)) |=> ##1 !rdata_valid);

   // R8: at any K edge the buffered burst is complete or absent
   p_pend_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (k_half && pend_valid) |-> pend_full);

   if (IDLE_ZERO) begin : g_idle
      // R9: released bus reads as zero
      p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !rdata_oe |-> (rdata == '0));
   end

endmodule

bind ddrb_sram ddrb_sram_chk #(.DW(DW), .IDLE_ZERO(IDLE_ZERO)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .k_half      (k_half),
   .sel_n       (sel_n),
   .is_read     (is_read),
   .rdata_valid (rdata_valid),
   .rdata_oe    (rdata_oe),
   .rdata       (rdata),
   .pend_valid  (pend_valid),
   .pend_full   (pend_full)
);

// File: tb/sim_ddrb_sram.sv
module sim_ddrb_sram;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sel_n, is_read, flush;
   logic [3:0]  addr;
   logic [31:0] wdata;
   logic [3:0]  lane_we_n;
   logic        k_half;
   logic [31:0] rdata;
   logic        rdata_valid, rdata_oe;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] mdl [DEPTH*2];

   logic        prev_rd = 1'b0, prev_wr = 1'b0;
   logic [3:0]  prev_waddr = '0;
   logic [31:0] prev_e0 = '0, prev_e1 = '0;
   string       prev_tag = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   ddrb_sram u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .is_read(is_read), .addr(addr),
      .wdata(wdata), .lane_we_n(lane_we_n), .flush(flush), .k_half(k_half),
      .rdata(rdata), .rdata_valid(rdata_valid), .rdata_oe(rdata_oe)
   );

   task automatic chk(string tag, logic ev, logic [31:0] eq);
      n_chk++;
      if (rdata_valid !== ev || rdata_oe !== ev || rdata !== eq) begin
         n_fail++;
         $display("FAIL %s: valid=%b oe=%b data=%h, expected valid=%b oe=%b data=%h",
                  tag, rdata_valid, rdata_oe, rdata, ev, ev, eq);
      end
   endtask

   task automatic apply(logic [3:0] a, int beat, logic [31:0] d, logic [3:0] bw);
      for (int l = 0; l < 4; l++)
         if (!bw[l]) mdl[a*2+beat][l*8 +: 8] = d[l*8 +: 8];
   endtask

   // one command slot: a K half-cycle then a K# half-cycle; d*/bw* are the
   // data beats of the write issued in the previous slot (R5)
   task automatic kslot(logic sn, logic rd, logic [3:0] a, logic fl,
                        logic [31:0] d0, logic [3:0] bw0,
                        logic [31:0] d1, logic [3:0] bw1, string tag);
      logic [31:0] e0, e1;
      @(negedge clk);
      if (prev_rd) chk(prev_tag, 1'b1, prev_e0);
      else         chk(prev_tag, 1'b0, 32'h0);
      if (prev_wr) begin
         apply(prev_waddr, 0, d0, bw0);
         apply(prev_waddr, 1, d1, bw1);
      end
      sel_n     = sn;
      is_read   = rd;
      addr      = a;
      flush     = fl;
      wdata     = prev_wr ? d0 : 32'hA5A5_5A5A;
      lane_we_n = prev_wr ? bw0 : 4'h0;
      e0 = mdl[a*2];
      e1 = mdl[a*2+1];
      @(posedge clk);
      @(negedge clk);
      if (prev_rd) chk(prev_tag, 1'b1, prev_e1);
      else         chk(prev_tag, 1'b0, 32'h0);
      // K# half: command-like noise that must be ignored (R2)
      sel_n     = 1'b0;
      is_read   = 1'b1;
      addr      = ~a;
      flush     = 1'b1;
      wdata     = prev_wr ? d1 : 32'h5A5A_A5A5;
      lane_we_n = prev_wr ? bw1 : 4'h0;
      @(posedge clk);
      prev_rd    = !sn && rd;
      prev_wr    = !sn && !rd;
      prev_waddr = a;
      prev_e0    = e0;
      prev_e1    = e1;
      prev_tag   = tag;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; sel_n = 1'b1; is_read = 1'b0; addr = '0;
      flush = 1'b0; wdata = '0; lane_we_n = 4'hF;
      for (int i = 0; i < DEPTH*2; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1", 1'b0, 32'h0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", 1'b0, 32'h0);
      @(posedge clk);
   endtask

   task automatic t_blank_read;
      kslot(0, 1, 4'd3, 0, 0, 4'hF, 0, 4'hF, "R3");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R9");
   endtask

   task automatic t_forward;
      kslot(0, 0, 4'd5, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 1, 4'd5, 0, 32'h1111_0001, 4'h0, 32'h2222_0002, 4'h0, "R7");
      kslot(0, 1, 4'd5, 0, 0, 4'hF, 0, 4'hF, "R5");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R10");
   endtask

   task automatic t_back_to_back;
      kslot(0, 0, 4'd1, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 0, 4'd2, 0, 32'h0101_A0A0, 4'h0, 32'h0101_B1B1, 4'h0, "R10");
      kslot(0, 0, 4'd3, 0, 32'h0202_A0A0, 4'h0, 32'h0202_B1B1, 4'h0, "R10");
      kslot(1, 0, 4'd0, 0, 32'h0303_A0A0, 4'h0, 32'h0303_B1B1, 4'h0, "R10");
      kslot(0, 1, 4'd1, 0, 0, 4'hF, 0, 4'hF, "R4");
      kslot(0, 1, 4'd2, 0, 0, 4'hF, 0, 4'hF, "R4");
      kslot(0, 1, 4'd3, 0, 0, 4'hF, 0, 4'hF, "R4");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R10");
   endtask

   task automatic t_masks;
      kslot(0, 0, 4'd6, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 0, 4'd6, 0, 32'hAAAA_AAAA, 4'h0, 32'hBBBB_BBBB, 4'h0, "R10");
      // bytes 1,3 of the lower word and byte 0 of the upper word written (R6)
      kslot(0, 1, 4'd6, 0, 32'h1234_5678, 4'b0101, 32'h9ABC_DEF0, 4'b1110, "R6");
      kslot(0, 0, 4'd9, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(1, 0, 4'd0, 0, 32'hC0C0_C0C0, 4'h0, 32'hD0D0_D0D0, 4'h0, "R10");
      kslot(0, 1, 4'd6, 0, 0, 4'hF, 0, 4'hF, "R6");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R10");
   endtask

   task automatic t_flush;
      kslot(0, 0, 4'd10, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(1, 0, 4'd0, 1, 32'h0F0F_1234, 4'h0, 32'hF0F0_5678, 4'h0, "R10");
      kslot(1, 0, 4'd0, 1, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 1, 4'd10, 0, 0, 4'hF, 0, 4'hF, "R8");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R10");
   endtask

   task automatic t_mixed;
      kslot(0, 0, 4'd12, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 1, 4'd12, 0, 32'h1200_0001, 4'h0, 32'h1200_0002, 4'h0, "R11");
      kslot(0, 0, 4'd13, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 1, 4'd12, 0, 32'h1300_0001, 4'h0, 32'h1300_0002, 4'h0, "R11");
      kslot(0, 0, 4'd12, 0, 0, 4'hF, 0, 4'hF, "R10");
      kslot(0, 1, 4'd13, 0, 32'hEEEE_EEEE, 4'b0011, 32'hFFFF_FFFF, 4'b1100, "R11");
      kslot(0, 1, 4'd12, 0, 0, 4'hF, 0, 4'hF, "R11");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R10");
   endtask

   task automatic t_ksharp_noise;
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R2");
      kslot(1, 1, 4'd7, 0, 0, 4'hF, 0, 4'hF, "R2");
      kslot(1, 0, 4'd0, 0, 0, 4'hF, 0, 4'hF, "R2");
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_blank_read();
      t_forward();
      t_back_to_back();
      t_masks();
      t_flush();
      t_mixed();
      t_ksharp_noise();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule